// File: doc/BRIEF.md
# Configuration Port Sequencer

This block runs one complete frame update over an on-chip configuration port that moves one byte per cycle. A single start pulse, which carries a frame address, starts two phases in a fixed order. The first phase reads the addressed frame back into an external merge buffer. The second phase writes the buffer content back through the port. Each phase has five steps: a synchronisation sequence, a register command header, the frame bytes, a dummy flush frame and a desynchronisation sequence. The header is a command word followed by the frame address, most significant byte first. After the last byte of the write phase the block raises a one-cycle done pulse toward the request controller.

The port enable marks a cycle as a transfer cycle, and the direction signal says who drives the data. A byte moves only on a rising edge where enable is high and the port's busy input is low. While busy is high the sequencer holds its position and keeps all of its outputs steady. Whenever the data direction changes, the sequencer first spends one cycle with enable low. The command words, the sequence lengths, the frame length and the dummy length are all parameters.

Top module: `cfg_port_sequencer`

## Requirements
- R1: While reset is asserted, `port_en_o`, `done_o` and `buf_we_o` are low.
- R2: In the read phase, the port transfers appear in this order. First the `SYNC_LEN` bytes of `SYNC_SEQ`, then the `CMD_LEN` bytes of `RD_CMD`, then the `ADDR_W/8` bytes of the captured frame address. Each of these vectors is sent most significant byte first. Then come `FRAME_BYTES` received bytes, then `DUMMY_BYTES` received bytes, then the `DESYNC_LEN` bytes of `DESYNC_SEQ`.
- R3: The write phase follows the read phase. It sends the sync bytes, the `WR_CMD` bytes and the address bytes, in the same byte order as in R2. Next it sends `FRAME_BYTES` bytes, taking byte i from buffer address i. It then sends `DUMMY_BYTES` bytes of 0x00, followed by the desync bytes.
- R4: A byte transfers only on an edge with `port_en_o`=1 and `port_busy_i`=0. While busy is high, the position in the sequence does not advance, and `port_wr_o` and `buf_raddr_o` stay stable.
- R5: The i-th frame byte received in the read phase is written to buffer address i, on the edge where it transfers. `buf_we_o` is high only in such cycles, so bytes of the read dummy frame are not stored.
- R6: `port_wr_o` is 1 for the sync, header and desync steps and for all write-phase bytes. It is 0 for the read-phase frame and dummy bytes. In the cycle before `port_wr_o` changes, `port_en_o` is low.
- R7: `done_o` is high for exactly one cycle, in the cycle after the edge that transfers the last desync byte of the write phase. It is never high at any other time.
- R8: The block accepts `start_i` only while idle and captures `frame_addr_i` at that moment. A start during a running update has no effect, and neither does a later change of `frame_addr_i`.
- R9: While idle, `port_en_o` and `buf_we_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse from the request controller |
| frame_addr_i | input | ADDR_W | Frame address, captured at start |
| done_o | output | 1 | One-cycle completion pulse |
| port_en_o | output | 1 | Port enable |
| port_wr_o | output | 1 | Port direction, 1 = sequencer drives data |
| port_din_o | output | 8 | Byte driven into the port |
| port_dout_i | input | 8 | Byte returned by the port |
| port_busy_i | input | 1 | Port cannot transfer this cycle |
| buf_we_o | output | 1 | Buffer write strobe for read-back bytes |
| buf_waddr_o | output | BUF_AW | Buffer write address |
| buf_wdata_o | output | 8 | Buffer write data |
| buf_raddr_o | output | BUF_AW | Buffer read address, read combinationally |
| buf_rdata_i | input | 8 | Buffer read data |

## Verification
The hardest cases to reach are a busy input that lands exactly on the last byte of a step, and one that lands on the first cycle after a direction turnaround. In both cases the step change and the stall interact. A second hard case is a start pulse, with a new address, arriving while an update is half done. The stimulus covers these with several busy patterns: none, pseudo-random, regular bursts, and a long initial stretch followed by sparse hits. One run also pulses start and changes the address in the middle of the update, and another asserts reset mid-update and then runs a fresh update.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [1:0] {CTL_IDLE, CTL_RUN, CTL_GAP} ctl_e;
  typedef enum logic {PH_READ, PH_WRITE} phase_e;
  typedef enum logic [2:0] {STP_SYNC, STP_CMD, STP_DATA, STP_DUMMY, STP_DESYNC} step_e;

  // 1 when the sequencer drives the port data in this step
  function automatic logic port_drives(phase_e p, step_e s);
    return !(p == PH_READ && (s == STP_DATA || s == STP_DUMMY));
  endfunction

  function automatic step_e step_after(step_e s);
    case (s)
      STP_SYNC:  return STP_CMD;
      STP_CMD:   return STP_DATA;
      STP_DATA:  return STP_DUMMY;
      STP_DUMMY: return STP_DESYNC;
      default:   return STP_SYNC;
    endcase
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cps_rst_sync.sv
module cps_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/cps_byte_ctr.sv
module cps_byte_ctr #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == last_i);

  AST_CNT_WITHIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i); // R2
endmodule

// File: rtl/cps_cmd_rom.sv
module cps_cmd_rom
  import cps_pkg::*;
#(
  parameter int                      SYNC_LEN   = 4,
  parameter logic [8*SYNC_LEN-1:0]   SYNC_SEQ   = 32'hA5C3_3C5A,
  parameter int                      CMD_LEN    = 4,
  parameter logic [8*CMD_LEN-1:0]    RD_CMD     = 32'h51C0_0E01,
  parameter logic [8*CMD_LEN-1:0]    WR_CMD     = 32'h61C0_0E02,
  parameter int                      ADDR_W     = 32,
  parameter int                      DESYNC_LEN = 2,
  parameter logic [8*DESYNC_LEN-1:0] DESYNC_SEQ = 16'hD55D,
  parameter int                      IDX_W      = 10
) (
  input  phase_e            phase_i,
  input  step_e             step_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [7:0]        byte_o
);
  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int HDR_LEN    = CMD_LEN + ADDR_BYTES;

  logic [8*ADDR_BYTES-1:0] addr_pad;
  logic [7:0] sync_b [SYNC_LEN];
  logic [7:0] rd_b   [HDR_LEN];
  logic [7:0] wr_b   [HDR_LEN];
  logic [7:0] ds_b   [DESYNC_LEN];

  assign addr_pad = (8*ADDR_BYTES)'(addr_i);

  // all multi-byte vectors go out most significant byte first
  for (genvar g = 0; g < SYNC_LEN; g++) begin : g_sync
    assign sync_b[g] = SYNC_SEQ[8*(SYNC_LEN-1-g) +: 8];
  end

  for (genvar g = 0; g < HDR_LEN; g++) begin : g_hdr
    if (g < CMD_LEN) begin : g_cmd
      assign rd_b[g] = RD_CMD[8*(CMD_LEN-1-g) +: 8];
      assign wr_b[g] = WR_CMD[8*(CMD_LEN-1-g) +: 8];
    end else begin : g_adr
      assign rd_b[g] = addr_pad[8*(HDR_LEN-1-g) +: 8];
      assign wr_b[g] = addr_pad[8*(HDR_LEN-1-g) +: 8];
    end
  end

  for (genvar g = 0; g < DESYNC_LEN; g++) begin : g_desync
    assign ds_b[g] = DESYNC_SEQ[8*(DESYNC_LEN-1-g) +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    case (step_i)
      STP_SYNC: begin
        for (int k = 0; k < SYNC_LEN; k++)
          if (idx_i == IDX_W'(k)) byte_o = sync_b[k];
      end
      STP_CMD: begin
        for (int k = 0; k < HDR_LEN; k++)
          if (idx_i == IDX_W'(k)) byte_o = (phase_i == PH_READ) ? rd_b[k] : wr_b[k];
      end
      STP_DESYNC: begin
        for (int k = 0; k < DESYNC_LEN; k++)
          if (idx_i == IDX_W'(k)) byte_o = ds_b[k];
      end
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/cps_seq_fsm.sv
module cps_seq_fsm
  import cps_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   busy_i,
  input  logic   last_i,
  output ctl_e   ctl_o,
  output phase_e phase_o,
  output step_e  step_o,
  output logic   accept_o,
  output logic   xfer_o,
  output logic   ctr_clr_o,
  output logic   ctr_adv_o,
  output logic   done_o
);
  ctl_e   ctl_q, ctl_d;
  phase_e phase_q, phase_d;
  step_e  step_q, step_d;
  logic   done_q, done_d;
  logic   xfer;

  assign xfer = (ctl_q == CTL_RUN) && !busy_i;

  always_comb begin
    ctl_d     = ctl_q;
    phase_d   = phase_q;
    step_d    = step_q;
    done_d    = 1'b0;
    accept_o  = 1'b0;
    ctr_clr_o = 1'b0;
    ctr_adv_o = 1'b0;
    case (ctl_q)
      CTL_IDLE: begin
        if (start_i) begin
          accept_o  = 1'b1;
          ctr_clr_o = 1'b1;
          ctl_d     = CTL_RUN;
          phase_d   = PH_READ;
          step_d    = STP_SYNC;
        end
      end
      CTL_RUN: begin
        if (xfer) begin
          if (last_i) begin
            ctr_clr_o = 1'b1;
            if (step_q == STP_DESYNC) begin
              if (phase_q == PH_WRITE) begin
                ctl_d  = CTL_IDLE;
                done_d = 1'b1;
              end else begin
                phase_d = PH_WRITE;
                step_d  = STP_SYNC;
              end
            end else if (port_drives(phase_q, step_after(step_q)) != port_drives(phase_q, step_q)) begin
              ctl_d = CTL_GAP;
            end else begin
              step_d = step_after(step_q);
            end
          end else begin
            ctr_adv_o = 1'b1;
          end
        end
      end
      CTL_GAP: begin
        ctl_d  = CTL_RUN;
        step_d = step_after(step_q);
      end
      default: ctl_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= CTL_IDLE;
      phase_q <= PH_READ;
      step_q  <= STP_SYNC;
      done_q  <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      phase_q <= phase_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign ctl_o   = ctl_q;
  assign phase_o = phase_q;
  assign step_o  = step_q;
  assign xfer_o  = xfer;
  assign done_o  = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (ctl_q == CTL_IDLE && phase_q == PH_WRITE && step_q == STP_DESYNC)); // R7
  AST_GAP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q == CTL_GAP) |=> (ctl_q == CTL_RUN)); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q == CTL_RUN && busy_i) |=> (ctl_q == CTL_RUN && $stable(step_q) && $stable(phase_q))); // R4
endmodule

// File: rtl/cfg_port_sequencer.sv
module cfg_port_sequencer
  import cps_pkg::*;
#(
  parameter int                      ADDR_W      = 32,
  parameter int                      SYNC_LEN    = 4,
  parameter logic [8*SYNC_LEN-1:0]   SYNC_SEQ    = 32'hA5C3_3C5A,
  parameter int                      CMD_LEN     = 4,
  parameter logic [8*CMD_LEN-1:0]    RD_CMD      = 32'h51C0_0E01,
  parameter logic [8*CMD_LEN-1:0]    WR_CMD      = 32'h61C0_0E02,
  parameter int                      DESYNC_LEN  = 2,
  parameter logic [8*DESYNC_LEN-1:0] DESYNC_SEQ  = 16'hD55D,
  parameter int                      FRAME_BYTES = 824,
  parameter int                      DUMMY_BYTES = 824,
  localparam int                     BUF_AW      = $clog2(FRAME_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] frame_addr_i,
  output logic              done_o,
  output logic              port_en_o,
  output logic              port_wr_o,
  output logic [7:0]        port_din_o,
  input  logic [7:0]        port_dout_i,
  input  logic              port_busy_i,
  output logic              buf_we_o,
  output logic [BUF_AW-1:0] buf_waddr_o,
  output logic [7:0]        buf_wdata_o,
  output logic [BUF_AW-1:0] buf_raddr_o,
  input  logic [7:0]        buf_rdata_i
);
  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int HDR_LEN    = CMD_LEN + ADDR_BYTES;
  localparam int MAX_LEN    = max2(max2(max2(SYNC_LEN, HDR_LEN), max2(FRAME_BYTES, DUMMY_BYTES)), DESYNC_LEN);
  localparam int IDX_W      = max2($clog2(MAX_LEN), 1);

  logic              rst_ns;
  ctl_e              ctl;
  phase_e            phase;
  step_e             step;
  logic              accept, xfer, ctr_clr, ctr_adv, at_last;
  logic [IDX_W-1:0]  idx, step_last;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        rom_byte;

  cps_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_ns)
  );

  cps_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ns),
    .start_i   (start_i),
    .busy_i    (port_busy_i),
    .last_i    (at_last),
    .ctl_o     (ctl),
    .phase_o   (phase),
    .step_o    (step),
    .accept_o  (accept),
    .xfer_o    (xfer),
    .ctr_clr_o (ctr_clr),
    .ctr_adv_o (ctr_adv),
    .done_o    (done_o)
  );

  always_comb begin
    case (step)
      STP_SYNC:  step_last = IDX_W'(SYNC_LEN - 1);
      STP_CMD:   step_last = IDX_W'(HDR_LEN - 1);
      STP_DATA:  step_last = IDX_W'(FRAME_BYTES - 1);
      STP_DUMMY: step_last = IDX_W'(DUMMY_BYTES - 1);
      default:   step_last = IDX_W'(DESYNC_LEN - 1);
    endcase
  end

  cps_byte_ctr #(.W(IDX_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ns),
    .clr_i  (ctr_clr),
    .adv_i  (ctr_adv),
    .last_i (step_last),
    .cnt_o  (idx),
    .last_o (at_last)
  );

  cps_cmd_rom #(
    .SYNC_LEN   (SYNC_LEN),
    .SYNC_SEQ   (SYNC_SEQ),
    .CMD_LEN    (CMD_LEN),
    .RD_CMD     (RD_CMD),
    .WR_CMD     (WR_CMD),
    .ADDR_W     (ADDR_W),
    .DESYNC_LEN (DESYNC_LEN),
    .DESYNC_SEQ (DESYNC_SEQ),
    .IDX_W      (IDX_W)
  ) u_rom (
    .phase_i (phase),
    .step_i  (step),
    .idx_i   (idx),
    .addr_i  (addr_q),
    .byte_o  (rom_byte)
  );

  // frame address is captured once per update, at the accepted start
  always_ff @(posedge clk_i or negedge rst_ns) begin
    if (!rst_ns)     addr_q <= '0;
    else if (accept) addr_q <= frame_addr_i;
  end

  assign port_en_o = (ctl == CTL_RUN);
  assign port_wr_o = port_drives(phase, step);

  always_comb begin
    if (phase == PH_WRITE && step == STP_DATA)   port_din_o = buf_rdata_i;
    else if (step == STP_DATA || step == STP_DUMMY) port_din_o = 8'h00;
    else                                          port_din_o = rom_byte;
  end

  assign buf_we_o    = xfer && (phase == PH_READ) && (step == STP_DATA);
  assign buf_waddr_o = idx[BUF_AW-1:0];
  assign buf_wdata_o = port_dout_i;
  assign buf_raddr_o = idx[BUF_AW-1:0];

  AST_DIR_SWITCH_GAP: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (port_wr_o != $past(port_wr_o)) |-> !$past(port_en_o)); // R6
  AST_HOLD_ON_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (port_en_o && port_busy_i) |=> (port_en_o && $stable(port_wr_o) && $stable(buf_raddr_o))); // R4
  AST_QUIET_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ns)
    done_o |-> (!port_en_o && !buf_we_o)); // R9
endmodule

// File: tb/cfg_port_sequencer_tb_top.sv
`timescale 1ns/1ps
module cfg_port_sequencer_tb_top;
  localparam int              ADDR_W      = 32;
  localparam int              SYNC_LEN    = 4;
  localparam logic [31:0]     SYNC_SEQ    = 32'hA5C3_3C5A;
  localparam int              CMD_LEN     = 4;
  localparam logic [31:0]     RD_CMD      = 32'h51C0_0E01;
  localparam logic [31:0]     WR_CMD      = 32'h61C0_0E02;
  localparam int              DESYNC_LEN  = 2;
  localparam logic [15:0]     DESYNC_SEQ  = 16'hD55D;
  localparam int              FRAME_BYTES = 24;
  localparam int              DUMMY_BYTES = 6;
  localparam int              AW          = $clog2(FRAME_BYTES);
  localparam int              OP_LIMIT    = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] frame_addr_i = '0;
  logic done_o, port_en_o, port_wr_o, buf_we_o;
  logic [7:0] port_din_o, buf_wdata_o, buf_rdata_i;
  logic [7:0] port_dout_i = 8'h00;
  logic port_busy_i = 1'b0;
  logic [AW-1:0] buf_waddr_o, buf_raddr_o;

  always #2.5 clk = ~clk;

  cfg_port_sequencer #(
    .ADDR_W(ADDR_W), .SYNC_LEN(SYNC_LEN), .SYNC_SEQ(SYNC_SEQ), .CMD_LEN(CMD_LEN),
    .RD_CMD(RD_CMD), .WR_CMD(WR_CMD), .DESYNC_LEN(DESYNC_LEN), .DESYNC_SEQ(DESYNC_SEQ),
    .FRAME_BYTES(FRAME_BYTES), .DUMMY_BYTES(DUMMY_BYTES)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .frame_addr_i(frame_addr_i),
    .done_o(done_o), .port_en_o(port_en_o), .port_wr_o(port_wr_o),
    .port_din_o(port_din_o), .port_dout_i(port_dout_i), .port_busy_i(port_busy_i),
    .buf_we_o(buf_we_o), .buf_waddr_o(buf_waddr_o), .buf_wdata_o(buf_wdata_o),
    .buf_raddr_o(buf_raddr_o), .buf_rdata_i(buf_rdata_i)
  );

  // merge buffer model: synchronous write, combinational read
  logic [7:0] mem [FRAME_BYTES];
  always @(posedge clk) if (buf_we_o && int'(buf_waddr_o) < FRAME_BYTES) mem[buf_waddr_o] <= buf_wdata_o;
  assign buf_rdata_i = (int'(buf_raddr_o) < FRAME_BYTES) ? mem[buf_raddr_o] : 8'h00;

  int n_cmp = 0;
  int n_bad = 0;
  // expected transfer list: kind 0 = byte driven by the block, 1 = stored read byte, 2 = read dummy byte
  int         qk[$];
  logic [7:0] qv[$];
  int         qi[$];
  string      qr[$];
  logic expd = 1'b0;
  logic prev_en = 1'b0;
  logic prev_wr = 1'b1;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic push(input int k, input logic [7:0] v, input int i, input string r);
    qk.push_back(k); qv.push_back(v); qi.push_back(i); qr.push_back(r);
  endtask

  function automatic logic [7:0] rbv(input int op, input int i);
    return 8'((op * 37) + (i * 11) + 5);
  endfunction

  task automatic push_hdr(input logic [31:0] cmd, input logic [31:0] addr, input string r);
    for (int k = 0; k < SYNC_LEN; k++)   push(0, 8'(SYNC_SEQ >> (8*(SYNC_LEN-1-k))), 0, r);
    for (int k = 0; k < CMD_LEN; k++)    push(0, 8'(cmd >> (8*(CMD_LEN-1-k))), 0, r);
    for (int k = 0; k < ADDR_W/8; k++)   push(0, 8'(addr >> (8*(ADDR_W/8-1-k))), 0, r);
  endtask

  task automatic push_desync(input string r);
    for (int k = 0; k < DESYNC_LEN; k++) push(0, 8'(DESYNC_SEQ >> (8*(DESYNC_LEN-1-k))), 0, r);
  endtask

  task automatic build_op(input logic [31:0] addr, input int op);
    push_hdr(RD_CMD, addr, "R2");
    for (int i = 0; i < FRAME_BYTES; i++) push(1, rbv(op, i), i, "R2");
    for (int i = 0; i < DUMMY_BYTES; i++) push(2, ~rbv(op, i), 0, "R2");
    push_desync("R2");
    push_hdr(WR_CMD, addr, "R3");
    for (int i = 0; i < FRAME_BYTES; i++) push(0, rbv(op, i), i, "R3");
    for (int i = 0; i < DUMMY_BYTES; i++) push(0, 8'h00, 0, "R3");
    push_desync("R3");
  endtask

  function automatic logic busy_for(input int mode, input int t, input logic rnd);
    case (mode)
      1: return rnd;
      2: return (t % 8) < 5;
      3: return (t < 40) || (t % 13 == 0);
      default: return 1'b0;
    endcase
  endfunction

  // one clock: drive at the falling edge, check after settling
  task automatic cycle_step(input int mode, input int t, input logic st, input logic [31:0] addr);
    logic lastpop;
    @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    port_busy_i = busy_for(mode, t, lf[0] & lf[3]);
    start_i = st;
    frame_addr_i = addr;
    port_dout_i = (qk.size() > 0 && qk[0] != 0) ? qv[0] : 8'h3C;
    #1;
    lastpop = 1'b0;
    chk(done_o === expd, "R7 done timing", 32'(done_o), 32'(expd));
    if (prev_en && (port_wr_o !== prev_wr))
      chk(1'b0, "R6 direction changed while enabled", 32'(port_wr_o), 32'(prev_wr));
    if (port_en_o) begin
      if (qk.size() == 0) chk(1'b0, "R9 enable with no transfer pending", 32'(port_en_o), 32'd0);
      else if (!port_busy_i) begin
        if (qk[0] == 0) begin
          chk(port_wr_o === 1'b1, {qr[0], " direction"}, 32'(port_wr_o), 32'd1);
          chk(port_din_o === qv[0], {qr[0], " byte"}, 32'(port_din_o), 32'(qv[0]));
          chk(buf_we_o === 1'b0, "R5 store outside read data", 32'(buf_we_o), 32'd0);
        end else if (qk[0] == 1) begin
          chk(port_wr_o === 1'b0, "R6 read direction", 32'(port_wr_o), 32'd0);
          chk({buf_we_o, 8'(buf_waddr_o), buf_wdata_o} === {1'b1, 8'(qi[0]), qv[0]},
              "R5 read byte store", 32'({buf_we_o, 8'(buf_waddr_o), buf_wdata_o}),
              32'({1'b1, 8'(qi[0]), qv[0]}));
        end else begin
          chk(port_wr_o === 1'b0, "R6 read dummy direction", 32'(port_wr_o), 32'd0);
          chk(buf_we_o === 1'b0, "R5 dummy byte stored", 32'(buf_we_o), 32'd0);
        end
        void'(qk.pop_front()); void'(qv.pop_front()); void'(qi.pop_front()); void'(qr.pop_front());
        if (qk.size() == 0) lastpop = 1'b1;
      end else begin
        chk(buf_we_o === 1'b0, "R4 store during busy", 32'(buf_we_o), 32'd0);
      end
    end else begin
      chk(buf_we_o === 1'b0, "R9 store while not enabled", 32'(buf_we_o), 32'd0);
    end
    expd = lastpop;
    prev_en = port_en_o;
    prev_wr = port_wr_o;
  endtask

  task automatic run_op(input logic [31:0] addr, input int op, input int mode, input bit midstart);
    int t;
    build_op(addr, op);
    cycle_step(mode, 0, 1'b1, addr);
    t = 1;
    while ((qk.size() > 0 || expd) && t < OP_LIMIT) begin
      // R8: a second start with another address mid-update must change nothing
      if (midstart && t == 15) cycle_step(mode, t, 1'b1, 32'hDEAD_BEEF);
      else                     cycle_step(mode, t, 1'b0, 32'h0BAD_F00D);
      t++;
    end
    if (t >= OP_LIMIT) begin
      chk(1'b0, "R7 update did not finish (watchdog)", 32'(qk.size()), 32'd0);
      qk.delete(); qv.delete(); qi.delete(); qr.delete();
      expd = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle_step(0, i, 1'b0, 32'h0);
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < FRAME_BYTES; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk({port_en_o, done_o, buf_we_o} === 3'b000, "R1 reset outputs", 32'({port_en_o, done_o, buf_we_o}), 32'd0);
    rst_n = 1'b1;
    idle(5);                                        // R9 quiet while idle
    run_op(32'h1234_5678, 1, 0, 1'b0);              // no busy
    idle(3);
    run_op(32'hFFFF_0001, 2, 1, 1'b1);              // random busy, start mid-run (R8)
    run_op(32'h0000_00A5, 3, 2, 1'b0);              // back to back, burst busy (R4)
    idle(2);
    run_op(32'h8001_7F00, 4, 3, 1'b1);              // long initial busy, sparse hits
    // reset in the middle of an update (R1), then a fresh update
    build_op(32'h5555_AAAA, 5);
    cycle_step(1, 0, 1'b1, 32'h5555_AAAA);
    for (int t = 1; t < 30; t++) cycle_step(1, t, 1'b0, 32'h0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({port_en_o, done_o, buf_we_o} === 3'b000, "R1 reset mid-update", 32'({port_en_o, done_o, buf_we_o}), 32'd0);
    qk.delete(); qv.delete(); qi.delete(); qr.delete();
    expd = 1'b0; prev_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    run_op(32'hC3C3_0F0F, 6, 1, 1'b0);
    idle(3);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end");
    finish_up();
  end
endmodule